// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This block is a bus master that moves bytes of read-only configuration items into system memory. Software places a 16-byte descriptor in memory and writes the descriptor's address to a doorbell register. The engine then fetches the descriptor. It can optionally switch to another item. It then either copies or skips a byte count starting at the current position in the current item. When the item runs out, copying continues with zero bytes. At the end, the engine writes a completion word back over the descriptor's control field.

The items are generated on chip and can also be read through a separate keyed byte port. The item position is kept from one transfer to the next, so a long item can be consumed in several descriptors. Memory accesses are single bytes, one per accepted request, and any access can return an error.

Top module: `cfg_dma_engine`

## Requirements
- R1: A doorbell write of size 4 at offset 0 replaces the stored address with the written 32 bits shifted into the upper half and does not start a transfer. A size-4 write at offset 4 ORs the 32 bits into the lower half and starts a transfer at the result. A size-8 write at offset 0 starts a transfer at the written value. Every other size/offset write raises `reg_reject` for that cycle and has no effect.
- R2: A doorbell read returns the bytes at offsets `reg_off` to `reg_off+reg_size-1` of the big-endian constant 0x51454D5520434647. The bytes are right-justified in `reg_rdata` in the same order, and all upper bytes are zero.
- R3: A transfer starts by reading the 16 descriptor bytes in ascending address order. Byte 0 is the most significant byte. The descriptor holds a 32-bit control word, then a 32-bit length, then a 64-bit destination address. A request is held with a stable address until `mem_ack`.
- R4: Control bit 3 (select) sets the current item to key = control[31:16] and its position to 0. A key equal to or above NUM_ITEMS gives an invalid item that has no bytes.
- R5: Control bit 1 (copy) takes priority over bit 2 (skip). If neither bit is set, the length is treated as zero and no data access is made.
- R6: In copy mode, each destination byte is written in ascending address order. The byte written is the item byte at the current position, and the position advances by one. If the item is invalid or exhausted, the byte written is 0x00.
- R7: Skip mode makes no memory access. It advances the item position by the smaller of the length and the bytes left in the item.
- R8: A memory error on a data write stops the transfer, and the completion word becomes 0x00000001. A transfer without errors gives 0x00000000. The item position counts only the bytes that were written without error.
- R9: The completion word is always written big-endian, as four byte writes to the descriptor address plus 0 to 3. If the descriptor fetch fails, only the completion word 0x00000001 is written. Errors on these four writes are ignored.
- R10: The stored doorbell address is cleared to zero when a transfer starts.
- R11: `busy` rises in the cycle after an accepted start and falls after the last completion byte is accepted. Doorbell writes made while busy are rejected.
- R12: After reset, the current item is key 0 at position 0. Item k (k < NUM_ITEMS) has 3+5k bytes, and byte i of item k is (0x40 + 32k + i) mod 256. The keyed port reports a hit and that byte, or no hit and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Doorbell write strobe |
| reg_rd | input | 1 | Doorbell read strobe |
| reg_off | input | 3 | Byte offset of the access |
| reg_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| reg_wdata | input | 64 | Write data, right-justified |
| reg_rdata | output | 64 | Read data, right-justified |
| reg_reject | output | 1 | Write refused this cycle |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | Accepted request failed |
| mem_rdata | input | 8 | Read byte, valid with ack |
| item_key | input | 16 | Keyed port item key |
| item_off | input | 32 | Keyed port byte position |
| item_data | output | 8 | Keyed port byte |
| item_hit | output | 1 | Position lies inside a valid item |

## Verification
A doorbell trigger can arrive in the same cycle as work on an earlier transfer. The bench provokes this by issuing a full-width doorbell write a few cycles into a 20-byte copy, with wait states on the memory. It judges the result by three things: `reg_reject` at the port, the absence of any bus access that the reference model did not predict, and a follow-up copy that reads from the item position the first transfer left behind. A memory error on a data write is also made to fall mid-copy. The bench then checks that the item position, as seen by the next copy, counts only the bytes that were accepted.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  localparam logic [63:0] DB_SIGNATURE = 64'h5145_4D55_2043_4647;

  localparam int ADDR_W     = 64;
  localparam int LEN_W      = 32;
  localparam int KEY_W      = 16;
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int DESC_W     = 8 * DESC_BYTES;

  // control word bit positions
  localparam int CTL_ERR  = 0;
  localparam int CTL_COPY = 1;
  localparam int CTL_SKIP = 2;
  localparam int CTL_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_MOVE,
    ST_STATUS
  } xfer_state_e;

  function automatic logic [LEN_W-1:0] item_len(input logic [KEY_W-1:0] k,
                                                input int unsigned n);
    if (32'(k) < n) return 32'd3 + 32'd5 * 32'(k);
    return '0;
  endfunction

  function automatic logic [7:0] item_byte(input logic [KEY_W-1:0] k,
                                           input logic [LEN_W-1:0] i);
    return 8'(32'h40 + 32'd32 * 32'(k) + i);
  endfunction

endpackage

// File: rtl/cfgdma_rst_sync.sv
module cfgdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfgdma_items.sv
module cfgdma_items
  import cfgdma_pkg::*;
#(
  parameter int NUM_ITEMS = 4,
  parameter int NPORTS    = 2
) (
  input  logic [KEY_W-1:0] key   [NPORTS],
  input  logic [LEN_W-1:0] pos   [NPORTS],
  output logic [7:0]       data  [NPORTS],
  output logic             hit   [NPORTS],
  output logic [LEN_W-1:0] avail [NPORTS]
);
  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    logic [LEN_W-1:0] len_k;
    always_comb begin
      len_k     = item_len(key[gp], NUM_ITEMS);
      hit[gp]   = pos[gp] < len_k;
      data[gp]  = hit[gp] ? item_byte(key[gp], pos[gp]) : 8'h00;
      avail[gp] = hit[gp] ? (len_k - pos[gp]) : '0;
    end
  end
endmodule

// File: rtl/cfgdma_doorbell.sv
module cfgdma_doorbell
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  input  logic              busy,
  output logic [63:0]       reg_rdata,
  output logic              reg_reject,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              is_hi, is_lo, is_full, accept;

  always_comb begin
    is_hi      = (reg_size == 4'd4) && (reg_off == 3'd0);
    is_lo      = (reg_size == 4'd4) && (reg_off == 3'd4);
    is_full    = (reg_size == 4'd8) && (reg_off == 3'd0);
    accept     = reg_wr && !busy && (is_hi || is_lo || is_full);
    reg_reject = reg_wr && !accept;
    start      = accept && (is_lo || is_full);
    start_addr = is_full ? reg_wdata : (addr_q | {32'h0, reg_wdata[31:0]});
    addr_en    = accept;
    addr_d     = is_hi ? {reg_wdata[31:0], 32'h0} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // signature bytes, big-endian order, right-justified
  always_comb begin
    reg_rdata = '0;
    if (reg_rd && (int'(reg_off) + int'(reg_size) <= 8)) begin
      for (int b = 0; b < 8; b++) begin
        if (b < int'(reg_size)) begin
          reg_rdata[8*b +: 8] =
            DB_SIGNATURE[8*(7 - (int'(reg_off) + int'(reg_size) - 1 - b)) +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/cfgdma_xfer.sv
module cfgdma_xfer
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [7:0]        mem_rdata,
  output logic [KEY_W-1:0]  it_key,
  output logic [LEN_W-1:0]  it_pos,
  input  logic [7:0]        it_byte,
  input  logic [LEN_W-1:0]  it_avail
);
  localparam int IDX_W = $clog2(DESC_BYTES);

  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DESC_W-1:0] desc_q, desc_d;
  logic              desc_en;
  logic              copy_q, copy_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic              err_q, err_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [LEN_W-1:0]  pos_q, pos_d;

  logic [31:0]       ctl;
  logic [LEN_W-1:0]  dlen, step;
  logic [ADDR_W-1:0] dptr;
  logic              unused_ctl;

  assign ctl        = desc_q[DESC_W-1 -: 32];
  assign dlen       = desc_q[DESC_W-33 -: LEN_W];
  assign dptr       = desc_q[ADDR_W-1:0];
  assign unused_ctl = ^{ctl[15:4], ctl[CTL_ERR]};
  assign step       = (len_q < it_avail) ? len_q : it_avail;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    ptr_en    = 1'b0;
    idx_d     = idx_q;
    desc_d    = desc_q;
    desc_en   = 1'b0;
    copy_d    = copy_q;
    len_d     = len_q;
    dst_d     = dst_q;
    err_d     = err_q;
    key_d     = key_q;
    pos_d     = pos_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ptr_d   = start_addr;
          ptr_en  = 1'b1;
          idx_d   = '0;
          err_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + ADDR_W'(idx_q);
        if (mem_ack) begin
          if (mem_err) begin
            err_d   = 1'b1;
            idx_d   = '0;
            state_d = ST_STATUS;
          end else begin
            desc_d  = {desc_q[DESC_W-9:0], mem_rdata};
            desc_en = 1'b1;
            idx_d   = idx_q + 1'b1;
            if (idx_q == IDX_W'(DESC_BYTES - 1)) state_d = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (ctl[CTL_SEL]) begin
          key_d = ctl[31:16];
          pos_d = '0;
        end
        copy_d  = ctl[CTL_COPY];
        len_d   = (ctl[CTL_COPY] || ctl[CTL_SKIP]) ? dlen : '0;
        dst_d   = dptr;
        state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (len_q == '0) begin
          idx_d   = '0;
          state_d = ST_STATUS;
        end else if (copy_q) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = dst_q;
          mem_wdata = it_byte;
          if (mem_ack) begin
            if (mem_err) begin
              err_d   = 1'b1;
              idx_d   = '0;
              state_d = ST_STATUS;
            end else begin
              dst_d = dst_q + 1'b1;
              len_d = len_q - 1'b1;
              if (it_avail != '0) pos_d = pos_q + 1'b1;
            end
          end
        end else if (it_avail != '0) begin
          pos_d = pos_q + step;
          len_d = len_q - step;
          dst_d = dst_q + ADDR_W'(step);
        end else begin
          dst_d = dst_q + ADDR_W'(len_q);
          len_d = '0;
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + ADDR_W'(idx_q);
        mem_wdata = (idx_q == IDX_W'(STAT_BYTES - 1)) ? {7'd0, err_q} : 8'h00;
        if (mem_ack) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(STAT_BYTES - 1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      desc_q  <= '0;
      copy_q  <= 1'b0;
      len_q   <= '0;
      dst_q   <= '0;
      err_q   <= 1'b0;
      key_q   <= '0;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      idx_q   <= idx_d;
      if (desc_en) desc_q <= desc_d;
      copy_q  <= copy_d;
      len_q   <= len_d;
      dst_q   <= dst_d;
      err_q   <= err_d;
      key_q   <= key_d;
      pos_q   <= pos_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign it_key = key_q;
  assign it_pos = pos_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_first_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_we));

  assert_pos_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pos_q));

  assert_last_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfgdma_pkg::*;
#(
  parameter int NUM_ITEMS  = 4,
  parameter int RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_off,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        reg_reject,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [7:0]  mem_rdata,
  input  logic [15:0] item_key,
  input  logic [31:0] item_off,
  output logic [7:0]  item_data,
  output logic        item_hit
);
  localparam int NPORTS   = 2;
  localparam int P_ENGINE = 0;
  localparam int P_KEYED  = 1;

  logic              rst_q;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [KEY_W-1:0]  p_key   [NPORTS];
  logic [LEN_W-1:0]  p_pos   [NPORTS];
  logic [7:0]        p_data  [NPORTS];
  logic              p_hit   [NPORTS];
  logic [LEN_W-1:0]  p_avail [NPORTS];
  logic              unused_port;

  cfgdma_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  cfgdma_doorbell u_db (
    .clk        (clk),
    .rst_n      (rst_q),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_off    (reg_off),
    .reg_size   (reg_size),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .reg_rdata  (reg_rdata),
    .reg_reject (reg_reject),
    .start      (start),
    .start_addr (start_addr)
  );

  cfgdma_xfer u_xfer (
    .clk        (clk),
    .rst_n      (rst_q),
    .start      (start),
    .start_addr (start_addr),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_rdata  (mem_rdata),
    .it_key     (p_key[P_ENGINE]),
    .it_pos     (p_pos[P_ENGINE]),
    .it_byte    (p_data[P_ENGINE]),
    .it_avail   (p_avail[P_ENGINE])
  );

  assign p_key[P_KEYED] = item_key;
  assign p_pos[P_KEYED] = item_off;

  cfgdma_items #(.NUM_ITEMS(NUM_ITEMS), .NPORTS(NPORTS)) u_items (
    .key   (p_key),
    .pos   (p_pos),
    .data  (p_data),
    .hit   (p_hit),
    .avail (p_avail)
  );

  assign item_data   = p_data[P_KEYED];
  assign item_hit    = p_hit[P_KEYED];
  assign unused_port = p_hit[P_ENGINE] ^ (^p_avail[P_KEYED]);

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_q)
    start |=> busy);

  assert_busy_no_start_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && reg_wr) |-> reg_reject);
endmodule

// File: tb/sim_cfg_dma_engine.sv
`timescale 1ns/1ps
module sim_cfg_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_off;
  logic [3:0]  reg_size;
  logic [63:0] reg_wdata, reg_rdata;
  logic        reg_reject, busy;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] item_key;
  logic [31:0] item_off;
  logic [7:0]  item_data;
  logic        item_hit;

  always #2.5 clk = ~clk;

  cfg_dma_engine #(.NUM_ITEMS(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_reject(reg_reject),
    .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .item_key(item_key), .item_off(item_off), .item_data(item_data), .item_hit(item_hit)
  );

  localparam logic [63:0] BAD_BASE = 64'h8000;
  localparam int          NITEMS   = 4;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall  = 1'b0;
  bit done   = 1'b0;

  logic [7:0]  mem [logic [63:0]];
  bit          q_we [$];
  logic [63:0] q_a  [$];
  logic [7:0]  q_d  [$];
  string       q_t  [$];

  int m_key = 0;
  int m_pos = 0;

  function automatic bit is_bad(input logic [63:0] a);
    return (a[63:32] != 32'h0) || (a >= BAD_BASE && a < BAD_BASE + 64'd16);
  endfunction

  function automatic logic [7:0] rdm(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic int ilen(input int k);
    return (k >= 0 && k < NITEMS) ? 3 + 5 * k : 0;
  endfunction

  function automatic logic [7:0] ibyte(input int k, input int i);
    return 8'((32'h40 + 32 * k + i) % 256);
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [63:0] a, input logic [7:0] d, input string t);
    q_we.push_back(we); q_a.push_back(a); q_d.push_back(d); q_t.push_back(t);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // reference model: predicts every bus access of one transfer
  task automatic expect_xfer(input logic [63:0] da, output int stat);
    logic [7:0]  d [16];
    bit          ok = 1'b1;
    logic [31:0] ctl, ln;
    logic [63:0] dst;
    bit          cp, sk;
    int          av, n;
    for (int i = 0; i < 16; i++) begin
      push(1'b0, da + 64'(i), 8'h00, "R3");
      if (is_bad(da + 64'(i))) begin ok = 1'b0; break; end
      d[i] = rdm(da + 64'(i));
    end
    stat = 0;
    if (!ok) stat = 1;
    else begin
      ctl = {d[0], d[1], d[2], d[3]};
      ln  = {d[4], d[5], d[6], d[7]};
      dst = {d[8], d[9], d[10], d[11], d[12], d[13], d[14], d[15]};
      if (ctl[3]) begin m_key = int'(ctl[31:16]); m_pos = 0; end
      cp = ctl[1];
      sk = !cp && ctl[2];
      if (!cp && !sk) ln = 0;
      while (ln > 0) begin
        av = (m_pos < ilen(m_key)) ? ilen(m_key) - m_pos : 0;
        if (cp) begin
          push(1'b1, dst, (av > 0) ? ibyte(m_key, m_pos) : 8'h00, "R6");
          if (is_bad(dst)) begin stat = 1; break; end
          dst++; ln--;
          if (av > 0) m_pos++;
        end else begin
          n = (av > 0) ? ((int'(ln) < av) ? int'(ln) : av) : int'(ln);
          if (av > 0) m_pos += n;
          ln -= 32'(n);
        end
      end
    end
    for (int j = 0; j < 4; j++) push(1'b1, da + 64'(j), (j == 3) ? 8'(stat) : 8'h00, "R9");
  endtask

  task automatic put_desc(input logic [63:0] a, input logic [31:0] ctl,
                          input logic [31:0] ln, input logic [63:0] dst);
    logic [127:0] v;
    v = {ctl, ln, dst};
    for (int i = 0; i < 16; i++) mem[a + 64'(i)] = v[127 - 8*i -: 8];
  endtask

  task automatic db(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] w,
                    input bit exp_rej, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = w;
    #1;
    check(reg_reject == exp_rej, tag, $sformatf("reject=%0b", reg_reject),
          $sformatf("reject=%0b", exp_rej));
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_off = off; reg_size = sz;
    #1;
    check(reg_rdata == exp, "R2", $sformatf("%h", reg_rdata), $sformatf("%h", exp));
    reg_rd = 1'b0;
  endtask

  task automatic keyed(input int k, input int p, input bit eh, input logic [7:0] ed);
    @(negedge clk);
    item_key = 16'(k); item_off = 32'(p);
    #1;
    check(item_hit == eh && item_data == ed, "R12",
          $sformatf("hit=%0b data=%h", item_hit, item_data),
          $sformatf("hit=%0b data=%h", eh, ed));
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    check(!busy, tag, $sformatf("busy=%0b", busy), "busy=0");
    check(q_a.size() == 0, tag, $sformatf("%0d pending", q_a.size()), "0 pending");
  endtask

  task automatic go_full(input logic [63:0] da, input string tag, input int exp_stat);
    int st;
    expect_xfer(da, st);
    check(st == exp_stat, tag, $sformatf("model status %0d", st), $sformatf("%0d", exp_stat));
    db(3'd0, 4'd8, da, 1'b0, "R1");
    check(busy, "R11", $sformatf("busy=%0b", busy), "busy=1");
    wait_idle(tag);
    if (!is_bad(da))
      check(rdm(da + 64'd3) == 8'(st) && rdm(da) == 8'h00, "R9",
            $sformatf("%h", rdm(da + 64'd3)), $sformatf("%h", 8'(st)));
  endtask

  // memory responder and per-clock comparison against the model
  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_req && !(stall && (cyc % 3 == 0))) begin
        mem_ack = 1'b1;
        mem_err = is_bad(mem_addr);
        mem_rdata = rdm(mem_addr);
        if (q_a.size() == 0) begin
          check(1'b0, "R11", $sformatf("access %h", mem_addr), "no access");
        end else begin
          check(mem_we == q_we[0] && mem_addr == q_a[0] && (!mem_we || mem_wdata == q_d[0]),
                q_t[0], $sformatf("we=%0b a=%h d=%h", mem_we, mem_addr, mem_wdata),
                $sformatf("we=%0b a=%h d=%h", q_we[0], q_a[0], q_d[0]));
          void'(q_we.pop_front()); void'(q_a.pop_front());
          void'(q_d.pop_front()); void'(q_t.pop_front());
        end
        if (mem_we && !is_bad(mem_addr)) mem[mem_addr] = mem_wdata;
      end else begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int st;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_off = '0; reg_size = '0;
    reg_wdata = '0; item_key = '0; item_off = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(!busy && !mem_req && !reg_reject, "R12", $sformatf("busy=%0b req=%0b", busy, mem_req),
          "busy=0 req=0");

    // signature reads
    rd(3'd0, 4'd8, 64'h5145_4D55_2043_4647);
    rd(3'd0, 4'd1, 64'h51);
    rd(3'd4, 4'd4, 64'h2043_4647);
    rd(3'd3, 4'd2, 64'h5520);
    rd(3'd7, 4'd1, 64'h47);

    // keyed port
    keyed(1, 0, 1'b1, 8'h60);
    keyed(3, 17, 1'b1, 8'hB1);
    keyed(3, 18, 1'b0, 8'h00);
    keyed(9, 0, 1'b0, 8'h00);

    // copy from reset item (key 0, 3 bytes) past its end
    put_desc(64'h100, 32'h0000_0002, 32'd5, 64'h1000);
    go_full(64'h100, "R6", 0);
    check(rdm(64'h1002) == 8'h42 && rdm(64'h1004) == 8'h00, "R12",
          $sformatf("%h %h", rdm(64'h1002), rdm(64'h1004)), "42 00");

    // select + skip, then continue copying from the new position (split doorbell)
    stall = 1'b1;
    put_desc(64'h140, 32'h0002_000C, 32'd4, 64'h1100);
    go_full(64'h140, "R7", 0);
    put_desc(64'h180, 32'h0000_0002, 32'd3, 64'h1200);
    expect_xfer(64'h180, st);
    db(3'd0, 4'd4, 64'h0, 1'b0, "R1");
    check(!busy, "R1", $sformatf("busy=%0b", busy), "busy=0");
    db(3'd4, 4'd4, 64'h180, 1'b0, "R1");
    wait_idle("R7");
    check(rdm(64'h1200) == 8'h84, "R7", $sformatf("%h", rdm(64'h1200)), "84");

    // copy and skip both set: copy wins
    put_desc(64'h1C0, 32'h0001_000E, 32'd10, 64'h1300);
    go_full(64'h1C0, "R5", 0);
    // neither set: nothing moves, select still applies
    put_desc(64'h200, 32'h0001_0008, 32'd7, 64'h1400);
    go_full(64'h200, "R5", 0);
    put_desc(64'h240, 32'h0000_0002, 32'd2, 64'h1500);
    go_full(64'h240, "R4", 0);
    check(rdm(64'h1500) == 8'h60, "R4", $sformatf("%h", rdm(64'h1500)), "60");

    // invalid key
    put_desc(64'h280, 32'h0009_000A, 32'd3, 64'h1600);
    go_full(64'h280, "R4", 0);

    // data error mid-copy, position counts only accepted bytes
    stall = 1'b0;
    put_desc(64'h2C0, 32'h0002_000A, 32'd4, BAD_BASE - 64'd2);
    go_full(64'h2C0, "R8", 1);
    put_desc(64'h300, 32'h0000_0002, 32'd1, 64'h1700);
    go_full(64'h300, "R8", 0);
    check(rdm(64'h1700) == 8'h82, "R8", $sformatf("%h", rdm(64'h1700)), "82");

    // failed fetch, then the stored address must have been cleared
    expect_xfer(64'h1_0000_0100, st);
    db(3'd0, 4'd4, 64'h1, 1'b0, "R1");
    db(3'd4, 4'd4, 64'h100, 1'b0, "R10");
    wait_idle("R9");
    put_desc(64'h340, 32'h0000_0004, 32'd2, 64'h1800);
    expect_xfer(64'h340, st);
    db(3'd4, 4'd4, 64'h340, 1'b0, "R10");
    wait_idle("R10");
    check(rdm(64'h343) == 8'h00, "R10", $sformatf("%h", rdm(64'h343)), "00");

    // doorbell while busy is refused
    stall = 1'b1;
    put_desc(64'h380, 32'h0003_000A, 32'd20, 64'h2000);
    expect_xfer(64'h380, st);
    db(3'd0, 4'd8, 64'h380, 1'b0, "R1");
    repeat (3) @(negedge clk);
    db(3'd0, 4'd8, 64'h100, 1'b1, "R11");
    db(3'd4, 4'd4, 64'h100, 1'b1, "R11");
    wait_idle("R11");
    repeat (3) @(negedge clk);
    check(!busy && !mem_req, "R11", $sformatf("busy=%0b", busy), "busy=0");
    check(rdm(64'h2011) == 8'hB1 && rdm(64'h2012) == 8'h00, "R6",
          $sformatf("%h %h", rdm(64'h2011), rdm(64'h2012)), "b1 00");

    // illegal write shapes
    db(3'd0, 4'd2, 64'h380, 1'b1, "R1");
    db(3'd2, 4'd4, 64'h380, 1'b1, "R1");
    db(3'd4, 4'd8, 64'h380, 1'b1, "R1");
    db(3'd0, 4'd1, 64'h380, 1'b1, "R1");
    @(negedge clk);
    check(!busy, "R1", $sformatf("busy=%0b", busy), "busy=0");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule